// File: doc/BRIEF.md
# Quadrature Position Counter with Index Reset

This block keeps the position count of a quadrature encoder axis. A decoder in front of it supplies a one-cycle count pulse with a direction bit. The block also takes an index input, once per revolution, and a strobe input, an external capture event. A set of configuration inputs selects how the count wraps or resets, whether index or strobe events reload a preset position, and whether those events capture the count into latch registers.

The count runs from 0 to a programmable maximum. It holds the maximum as a valid value. The next up pulse wraps it to 0 and sets a sticky overflow flag. A down pulse at 0 loads the maximum and sets a sticky underflow flag. The reset policy can reset the count on every index edge, never reset it on an index edge (wrap only), or reset it on the first index edge only. An index reset gives 0 when the direction is up and the maximum when it is down.

The index and strobe inputs are asynchronous. Each passes through a two-flop synchronizer before its rising edge is detected. Clearing the enable input acts as a soft reset. It clears the count, the latches, the flags and the first-index memory, and it leaves all configuration inputs untouched.

Top module: `qpos_counter`

## Requirements
- R1: With `rst_n` low, or at any clock edge where `cfg_enable` is 0, `pos_cnt`, `idx_lat`, `stb_lat`, `ovf_flag`, `unf_flag` and the first-index memory become 0.
- R2: A count pulse with `cnt_dir`=1 adds one to the count, so the count can reach `cfg_max_pos`. An up pulse while the count equals `cfg_max_pos` gives a count of 0 and sets `ovf_flag`.
- R3: A count pulse with `cnt_dir`=0 subtracts one from the count. A down pulse at count 0 loads `cfg_max_pos` and sets `unf_flag`.
- R4: The flags are sticky. `flag_clr[0]`=1 clears `ovf_flag` and `flag_clr[1]`=1 clears `unf_flag`. If a flag is set and cleared in the same cycle, the set wins.
- R5: With `cfg_rst_mode`=0, every detected index rising edge sets the count to 0 when `cnt_dir`=1 and to `cfg_max_pos` when `cnt_dir`=0. With mode 1 or 3, an index edge never resets the count.
- R6: With `cfg_rst_mode`=2, only the first index rising edge after an enable or reset does the index reset of R5. Later edges do not reset the count until a soft reset.
- R7: With `cfg_idx_init`=2, an index rising edge loads `cfg_init_pos`. This load takes priority over an index reset and over a count pulse in the same cycle. Index-init values 0, 1 and 3 take no action.
- R8: `cfg_sw_init`=1 loads `cfg_init_pos` in every enabled cycle, above every other count update. With `cfg_stb_init`=2, a strobe rising edge loads `cfg_init_pos`, ranking below the index init. Strobe-init values 0, 1 and 3 take no action.
- R9: On a rising edge of `stb_in` XOR `cfg_stb_inv`, `stb_lat` takes the count held before that cycle's update. Setting `cfg_stb_inv`=1 therefore latches on falling edges of `stb_in`.
- R10: With `cfg_idx_lat_en`=1, an index rising edge copies the count held before that cycle's update into `idx_lat`. With `cfg_idx_lat_en`=0, `idx_lat` holds its value.
- R11: An input edge that is first sampled high at clock edge k takes effect on the outputs at clock edge k+2, because of the two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_pulse | input | 1 | Count-enable pulse from the decoder |
| cnt_dir | input | 1 | Count direction, 1 = up |
| idx_in | input | 1 | Index input, asynchronous |
| stb_in | input | 1 | Strobe input, asynchronous |
| cfg_enable | input | 1 | Counter enable; 0 = soft reset |
| cfg_rst_mode | input | 2 | 0 any index, 1 and 3 maximum only, 2 first index |
| cfg_idx_init | input | 2 | 2 = load preset on index edge |
| cfg_stb_init | input | 2 | 2 = load preset on strobe edge |
| cfg_sw_init | input | 1 | Load preset while high |
| cfg_stb_inv | input | 1 | Invert strobe before edge detection |
| cfg_idx_lat_en | input | 1 | Latch count on index edge |
| cfg_max_pos | input | W | Maximum position |
| cfg_init_pos | input | W | Preset position |
| flag_clr | input | 2 | Write-one-to-clear: bit 0 overflow, bit 1 underflow |
| pos_cnt | output | W | Current position count |
| idx_lat | output | W | Index-latched count |
| stb_lat | output | W | Strobe-latched count |
| ovf_flag | output | 1 | Sticky overflow flag |
| unf_flag | output | 1 | Sticky underflow flag |

## Verification
The hardest case to reach is a detected index edge that lands in the same cycle as a count pulse while an index init is armed. The edge appears only two clock edges after the pin rises. The stimulus raises `idx_in`, waits exactly two clock edges, and then drives a count pulse for one cycle so that both events meet. First-index mode needs a soft reset followed by two index edges, and the stimulus applies both. A long pseudo-random run then mixes every configuration against the reference model.

// File: rtl/qpos_counter.sv
module qpos_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_pulse,
  input  logic         cnt_dir,
  input  logic         idx_in,
  input  logic         stb_in,
  input  logic         cfg_enable,
  input  logic [1:0]   cfg_rst_mode,
  input  logic [1:0]   cfg_idx_init,
  input  logic [1:0]   cfg_stb_init,
  input  logic         cfg_sw_init,
  input  logic         cfg_stb_inv,
  input  logic         cfg_idx_lat_en,
  input  logic [W-1:0] cfg_max_pos,
  input  logic [W-1:0] cfg_init_pos,
  input  logic [1:0]   flag_clr,
  output logic [W-1:0] pos_cnt,
  output logic [W-1:0] idx_lat,
  output logic [W-1:0] stb_lat,
  output logic         ovf_flag,
  output logic         unf_flag
);

  logic [1:0] idx_sy, stb_sy;
  logic       idx_d, stb_d, first_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_sy <= '0;
      stb_sy <= '0;
      idx_d  <= 1'b0;
      stb_d  <= 1'b0;
    end else begin
      idx_sy <= {idx_sy[0], idx_in};
      stb_sy <= {stb_sy[0], stb_in ^ cfg_stb_inv};
      idx_d  <= idx_sy[1];
      stb_d  <= stb_sy[1];
    end
  end

  wire idx_rise = idx_sy[1] & ~idx_d;
  wire stb_rise = stb_sy[1] & ~stb_d;
  wire idx_load = idx_rise && (cfg_idx_init == 2'd2);
  wire stb_load = stb_rise && (cfg_stb_init == 2'd2);
  wire idx_clr  = idx_rise && ((cfg_rst_mode == 2'd0) ||
                               ((cfg_rst_mode == 2'd2) && !first_seen));
  wire preempt  = cfg_sw_init || idx_load || stb_load || idx_clr;
  wire wrap_up  = !preempt && cnt_pulse &&  cnt_dir && (pos_cnt == cfg_max_pos);
  wire wrap_dn  = !preempt && cnt_pulse && !cnt_dir && (pos_cnt == '0);

  logic [W-1:0] pos_nxt;
  always_comb begin
    pos_nxt = pos_cnt;
    if (cfg_sw_init || idx_load || stb_load) pos_nxt = cfg_init_pos;
    else if (idx_clr)                         pos_nxt = cnt_dir ? '0 : cfg_max_pos;
    else if (wrap_up)                         pos_nxt = '0;
    else if (wrap_dn)                         pos_nxt = cfg_max_pos;
    else if (cnt_pulse)                       pos_nxt = cnt_dir ? pos_cnt + 1'b1 : pos_cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_cnt    <= '0;
      idx_lat    <= '0;
      stb_lat    <= '0;
      ovf_flag   <= 1'b0;
      unf_flag   <= 1'b0;
      first_seen <= 1'b0;
    end else if (!cfg_enable) begin
      pos_cnt    <= '0;
      idx_lat    <= '0;
      stb_lat    <= '0;
      ovf_flag   <= 1'b0;
      unf_flag   <= 1'b0;
      first_seen <= 1'b0;
    end else begin
      pos_cnt  <= pos_nxt;
      if (idx_rise && cfg_idx_lat_en) idx_lat <= pos_cnt;
      if (stb_rise)                   stb_lat <= pos_cnt;
      ovf_flag <= wrap_up | (ovf_flag & ~flag_clr[0]);
      unf_flag <= wrap_dn | (unf_flag & ~flag_clr[1]);
      if (idx_rise && cfg_rst_mode == 2'd2) first_seen <= 1'b1;
    end
  end

  a_r1_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (pos_cnt == '0) && !ovf_flag && !unf_flag && (idx_lat == '0) && (stb_lat == '0));

  a_r2_ovf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && !preempt && cnt_pulse && cnt_dir && pos_cnt == cfg_max_pos)
      |=> (pos_cnt == '0) && ovf_flag);

  a_r3_unf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && !preempt && cnt_pulse && !cnt_dir && pos_cnt == '0)
      |=> (pos_cnt == $past(cfg_max_pos)) && unf_flag);

  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && ovf_flag && !flag_clr[0]) |=> ovf_flag);

  a_r4_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && unf_flag && !flag_clr[1]) |=> unf_flag);

  a_r6_first_once: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && first_seen && cfg_rst_mode == 2'd2 && !cfg_sw_init &&
     !idx_load && !stb_load && !cnt_pulse) |=> $stable(pos_cnt));

  a_r10_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && !cfg_idx_lat_en) |=> $stable(idx_lat));

endmodule

// File: tb/qpos_counter_tb.sv
module qpos_counter_tb_top;
  localparam int W = 16;
  logic clk = 0, rst_n = 0;
  logic cnt_pulse = 0, cnt_dir = 0, idx_in = 0, stb_in = 0, cfg_enable = 0;
  logic [1:0] cfg_rst_mode = 0, cfg_idx_init = 0, cfg_stb_init = 0, flag_clr = 0;
  logic cfg_sw_init = 0, cfg_stb_inv = 0, cfg_idx_lat_en = 0;
  logic [W-1:0] cfg_max_pos = 5, cfg_init_pos = 3;
  logic [W-1:0] pos_cnt, idx_lat, stb_lat;
  logic ovf_flag, unf_flag;

  always #4 clk = ~clk;

  qpos_counter #(.W(W)) dut_i (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference: history of sampled pins, integers for state
  int ih[$], sh[$];
  int m_pos = 0, m_idx = 0, m_stb = 0, m_ovf = 0, m_unf = 0, m_first = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ih = '{0, 0, 0}; sh = '{0, 0, 0};
      m_pos = 0; m_idx = 0; m_stb = 0; m_ovf = 0; m_unf = 0; m_first = 0;
    end else begin
      bit ir, sr;
      ir = (ih[1] == 1) && (ih[2] == 0);
      sr = (sh[1] == 1) && (sh[2] == 0);
      ih.push_front(int'(idx_in)); void'(ih.pop_back());
      sh.push_front(int'(stb_in ^ cfg_stb_inv)); void'(sh.pop_back());
      if (!cfg_enable) begin
        m_pos = 0; m_idx = 0; m_stb = 0; m_ovf = 0; m_unf = 0; m_first = 0;
      end else begin
        int old;
        old = m_pos;
        if (ir && cfg_idx_lat_en) m_idx = old;
        if (sr) m_stb = old;
        if (flag_clr[0]) m_ovf = 0;
        if (flag_clr[1]) m_unf = 0;
        if (cfg_sw_init || (ir && cfg_idx_init == 2) || (sr && cfg_stb_init == 2))
          m_pos = cfg_init_pos;
        else if (ir && (cfg_rst_mode == 0 || (cfg_rst_mode == 2 && m_first == 0)))
          m_pos = cnt_dir ? 0 : int'(cfg_max_pos);
        else if (cnt_pulse && cnt_dir)
          if (old == int'(cfg_max_pos)) begin m_pos = 0; m_ovf = 1; end
          else m_pos = (old + 1) % 65536;
        else if (cnt_pulse)
          if (old == 0) begin m_pos = cfg_max_pos; m_unf = 1; end
          else m_pos = old - 1;
        if (ir && cfg_rst_mode == 2) m_first = 1;
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk({cur_req, " pos"}, pos_cnt, m_pos);
    chk({cur_req, " idx_lat"}, idx_lat, m_idx);
    chk({cur_req, " stb_lat"}, stb_lat, m_stb);
    chk({cur_req, " ovf"}, ovf_flag, m_ovf);
    chk({cur_req, " unf"}, unf_flag, m_unf);
  end

  task automatic step(int n); repeat (n) @(negedge clk); endtask
  task automatic cnt(bit d, int n);
    cnt_dir = d; cnt_pulse = 1; step(n); cnt_pulse = 0; step(1);
  endtask
  task automatic idx_pulse(); idx_in = 1; step(4); idx_in = 0; step(4); endtask
  task automatic stb_pulse(); stb_in = 1; step(4); stb_in = 0; step(4); endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(2); rst_n = 1; step(1);
    chk("R1 reset pos", pos_cnt, 0); chk("R1 reset ovf", ovf_flag, 0);
    cfg_enable = 1; cfg_rst_mode = 1; step(1);
    cur_req = "R2"; cnt(1, 5);
    chk("R2 reaches max", pos_cnt, 5); chk("R2 no ovf at max", ovf_flag, 0);
    cnt(1, 1);
    chk("R2 wrap pos", pos_cnt, 0); chk("R2 ovf set", ovf_flag, 1);
    cur_req = "R4"; flag_clr = 2'b01; step(1); flag_clr = 0; step(1);
    chk("R4 ovf cleared", ovf_flag, 0);
    cur_req = "R3"; cnt(0, 1);
    chk("R3 underflow pos", pos_cnt, 5); chk("R3 unf set", unf_flag, 1);
    step(3); chk("R4 unf sticky", unf_flag, 1);
    flag_clr = 2'b10; step(1); flag_clr = 0; step(1);
    chk("R4 unf cleared", unf_flag, 0);
    cnt(0, 3); chk("R3 decrement", pos_cnt, 2);
    cur_req = "R11"; cfg_rst_mode = 0; cnt_dir = 1; idx_in = 1; step(2);
    chk("R11 not yet", pos_cnt, 2); step(1);
    chk("R5 index up reset", pos_cnt, 0);
    step(3); idx_in = 0; step(4);
    cur_req = "R5"; cnt(1, 4); cnt_dir = 0; idx_pulse();
    chk("R5 index down loads max", pos_cnt, 5);
    cfg_rst_mode = 1; cnt(0, 2); idx_pulse();
    chk("R5 mode1 no index reset", pos_cnt, 3);
    cur_req = "R6"; cfg_rst_mode = 2; cfg_enable = 0; step(1);
    chk("R1 soft reset", pos_cnt, 0);
    cfg_enable = 1; step(1);
    cnt(1, 3); cnt_dir = 1; idx_pulse();
    chk("R6 first index resets", pos_cnt, 0);
    cnt(1, 2); idx_pulse();
    chk("R6 second index ignored", pos_cnt, 2);
    cur_req = "R7"; cfg_rst_mode = 0; cfg_idx_init = 2; cnt_dir = 1; idx_in = 1; step(2);
    cnt_pulse = 1; step(1); cnt_pulse = 0;
    chk("R7 init beats count and reset", pos_cnt, 3);
    step(3); idx_in = 0; step(4);
    cfg_rst_mode = 1; cfg_idx_init = 1; cnt(1, 1); idx_pulse();
    chk("R7 code 1 no action", pos_cnt, 4);
    cur_req = "R10"; cfg_idx_init = 0; cfg_idx_lat_en = 1; idx_pulse();
    chk("R10 index latch", idx_lat, 4);
    cnt(1, 1); cfg_idx_lat_en = 0; idx_pulse();
    chk("R10 latch disabled holds", idx_lat, 4);
    cur_req = "R9"; stb_pulse(); chk("R9 strobe latch", stb_lat, 5);
    cnt(0, 2); cfg_stb_inv = 1; step(4);
    chk("R9 inverted polarity edge", stb_lat, 3);
    stb_in = 1; step(4); cnt(1, 1); stb_in = 0; step(4);
    chk("R9 falling edge latch", stb_lat, 4);
    cfg_stb_inv = 0; step(4);
    cur_req = "R8"; cfg_stb_init = 2; stb_pulse();
    chk("R8 strobe init", pos_cnt, 3);
    cnt(1, 2); cfg_stb_init = 1; stb_pulse();
    chk("R8 strobe code 1 no action", pos_cnt, 5);
    cfg_sw_init = 1; step(1); cfg_sw_init = 0; step(1);
    chk("R8 software init", pos_cnt, 3);
    cur_req = "R2 mix";
    for (int i = 0; i < 4000; i++) begin
      cnt_pulse = $urandom_range(0, 1); cnt_dir = $urandom_range(0, 1);
      if ($urandom_range(0, 9) == 0) idx_in = ~idx_in;
      if ($urandom_range(0, 9) == 0) stb_in = ~stb_in;
      if (i % 500 == 0) begin
        cfg_rst_mode = $urandom_range(0, 3); cfg_idx_init = $urandom_range(0, 3);
        cfg_stb_init = $urandom_range(0, 3); cfg_idx_lat_en = $urandom_range(0, 1);
        cfg_stb_inv = $urandom_range(0, 1); cfg_max_pos = $urandom_range(3, 20);
        cfg_init_pos = $urandom_range(0, 3);
      end
      cfg_sw_init = ($urandom_range(0, 63) == 0);
      cfg_enable = ($urandom_range(0, 199) != 0);
      flag_clr = ($urandom_range(0, 15) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
      step(1);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule